// File: doc/BRIEF.md
# Memory error summary tracker

This block sits beside a memory test engine and turns its stream of error events into a running summary. Each event names a failing word address, the word the engine expected, the word it read back, and the number of the test that found it. The bits in error are the XOR of the expected and read words. The block keeps these registers up to date as events arrive:

- the address extremes;
- a sticky mask of the bit positions that have failed;
- failing-bit statistics;
- the longest run of consecutive failing addresses;
- an error count for each test.

A report path sits alongside the summary. It emits one report for each distinct failure. A failure that repeats the previous event's address and bit pattern only raises a repeat count on the report already issued.

Software reads every result directly, because all results are registers. The average number of failing bits per event is the total-bits register divided by the event-count register. The block has no divider; software does that division. A synchronous clear input restarts the summary, for example at the start of a new test pass.

Top module: `memerr_summary`

## Requirements
- R1: An event is accepted only when `evt_valid` is high, `clear` is low and `evt_expect ^ evt_read` is non-zero. An event whose XOR is zero changes no output and produces no report.
- R2: `lo_addr` and `hi_addr` hold the smallest and largest accepted address since the last clear or reset.
- R3: `bit_mask` is the OR of the error bits of every accepted event.
- R4: For accepted events:
  - `event_count` counts them.
  - `total_bits` sums their failing-bit population counts.
  - `min_bits` and `max_bits` hold the smallest and largest single-event population count.
- R5: An accepted address extends the current run by one when it equals the previous accepted address plus one, computed modulo 2^ADDR_W. Every other accepted address, including a repeat of the same address, restarts the run at 1. `max_run` holds the longest run.
- R6: An accepted event is a new report when any of these holds: it is the first event since clear, its address differs from the previous accepted event, or its error bits differ from the previous accepted event. A new report does four things on the next cycle:
  - `rpt_valid` pulses high for exactly one cycle;
  - `rpt_addr` and `rpt_bits` take the event's address and error bits;
  - `rpt_test` takes the event's test number;
  - `rpt_repeat` becomes 1.
- R7: An accepted event with the same address and error bits as the previous accepted event gives no pulse. It increments `rpt_repeat` and leaves `rpt_addr`, `rpt_bits` and `rpt_test` unchanged, even when its test number differs.
- R8: Each accepted event increments the counter of its test number. Counter t occupies `test_err_cnt[t*CNT_W +: CNT_W]`.
- R9: `clear` and reset set `lo_addr` to all ones and every other output to zero. `clear` wins over an event presented in the same cycle. The first event after a clear is always a new report.
- R10: Every output reflects an accepted event from the cycle after the clock edge that sampled it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous restart of all statistics |
| evt_valid | input | 1 | Error event present this cycle |
| evt_addr | input | ADDR_W | Failing word address |
| evt_expect | input | DATA_W | Expected data word |
| evt_read | input | DATA_W | Data word read back |
| evt_test | input | TEST_W | Number of the test that found the error |
| lo_addr | output | ADDR_W | Lowest failing address |
| hi_addr | output | ADDR_W | Highest failing address |
| bit_mask | output | DATA_W | Accumulated failing-bit mask |
| total_bits | output | CNT_W+BITS_W | Sum of failing bits over all events |
| event_count | output | CNT_W | Number of accepted events |
| min_bits | output | BITS_W | Fewest failing bits in one event |
| max_bits | output | BITS_W | Most failing bits in one event |
| max_run | output | CNT_W | Longest run of consecutive failing addresses |
| test_err_cnt | output | 2^TEST_W*CNT_W | Packed error counter for each test number |
| rpt_valid | output | 1 | One-cycle pulse announcing a new distinct report |
| rpt_addr | output | ADDR_W | Address of the current report |
| rpt_bits | output | DATA_W | Error bits of the current report |
| rpt_test | output | TEST_W | Test number of the current report |
| rpt_repeat | output | CNT_W | Occurrences of the current report |

## Verification
Telling a repeat apart from a new report is the subtle part. The two differ only in whether the address and error bits match the previous accepted event. A zero-XOR event slipped between two identical failures must not break the repeat chain. So the stimulus deliberately does the following:

- sends back-to-back duplicates;
- sends a same-address event with different bits;
- sends a duplicate carrying another test number;
- sends a zero-XOR event between duplicates.

A queue of expected reports catches any spurious or missing pulse. A clear presented together with an event, followed by a fresh event, shows that the clear wins and that the first event afterwards is treated as new.

// File: rtl/memerr_pkg.sv
package memerr_pkg;
  typedef enum logic [1:0] {
    DEC_IDLE   = 2'd0,
    DEC_NEW    = 2'd1,
    DEC_REPEAT = 2'd2
  } dedup_e;
endpackage

// File: rtl/memerr_bitstats.sv
module memerr_bitstats #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  localparam int BITS_W = $clog2(DATA_W + 1),
  localparam int TOT_W  = CNT_W + BITS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              accept,
  input  logic [DATA_W-1:0] err_bits,
  output logic [BITS_W-1:0] err_pop,
  output logic [TOT_W-1:0]  total_bits,
  output logic [CNT_W-1:0]  event_count,
  output logic [BITS_W-1:0] min_bits,
  output logic [BITS_W-1:0] max_bits
);
  function automatic logic [BITS_W-1:0] pop_of(input logic [DATA_W-1:0] v);
    logic [BITS_W-1:0] n;
    n = '0;
    for (int i = 0; i < DATA_W; i++) n = n + BITS_W'(v[i]);
    return n;
  endfunction

  assign err_pop = pop_of(err_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_bits  <= '0;
      event_count <= '0;
      min_bits    <= '0;
      max_bits    <= '0;
    end else if (clear) begin
      total_bits  <= '0;
      event_count <= '0;
      min_bits    <= '0;
      max_bits    <= '0;
    end else if (accept) begin
      total_bits  <= total_bits + TOT_W'(err_pop);
      event_count <= event_count + 1'b1;
      if (event_count == '0 || err_pop < min_bits) min_bits <= err_pop;
      if (err_pop > max_bits) max_bits <= err_pop;
    end
  end
endmodule

// File: rtl/memerr_extent.sv
module memerr_extent #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              accept,
  input  logic              first,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] prev_addr,
  input  logic [DATA_W-1:0] err_bits,
  output logic [ADDR_W-1:0] lo_addr,
  output logic [ADDR_W-1:0] hi_addr,
  output logic [DATA_W-1:0] bit_mask,
  output logic [CNT_W-1:0]  cur_run,
  output logic [CNT_W-1:0]  max_run
);
  function automatic logic follows(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] p,
                                   input logic is_first);
    logic [ADDR_W-1:0] nxt;
    nxt = p + 1'b1;
    return !is_first && (a == nxt);
  endfunction

  logic [CNT_W-1:0] next_run;
  assign next_run = follows(addr, prev_addr, first) ? cur_run + 1'b1 : CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_addr  <= '1;
      hi_addr  <= '0;
      bit_mask <= '0;
      cur_run  <= '0;
      max_run  <= '0;
    end else if (clear) begin
      lo_addr  <= '1;
      hi_addr  <= '0;
      bit_mask <= '0;
      cur_run  <= '0;
      max_run  <= '0;
    end else if (accept) begin
      if (addr < lo_addr) lo_addr <= addr;
      if (addr > hi_addr) hi_addr <= addr;
      bit_mask <= bit_mask | err_bits;
      cur_run  <= next_run;
      if (next_run > max_run) max_run <= next_run;
    end
  end
endmodule

// File: rtl/memerr_dedup.sv
module memerr_dedup
  import memerr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TEST_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              accept,
  input  logic              first,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] err_bits,
  input  logic [TEST_W-1:0] test,
  output dedup_e            decision,
  output logic              rpt_valid,
  output logic [ADDR_W-1:0] rpt_addr,
  output logic [DATA_W-1:0] rpt_bits,
  output logic [TEST_W-1:0] rpt_test,
  output logic [CNT_W-1:0]  rpt_repeat
);
  always_comb begin
    if (!accept)                                              decision = DEC_IDLE;
    else if (first || addr != rpt_addr || err_bits != rpt_bits) decision = DEC_NEW;
    else                                                      decision = DEC_REPEAT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_valid  <= 1'b0;
      rpt_addr   <= '0;
      rpt_bits   <= '0;
      rpt_test   <= '0;
      rpt_repeat <= '0;
    end else if (clear) begin
      rpt_valid  <= 1'b0;
      rpt_addr   <= '0;
      rpt_bits   <= '0;
      rpt_test   <= '0;
      rpt_repeat <= '0;
    end else begin
      rpt_valid <= (decision == DEC_NEW);
      if (decision == DEC_NEW) begin
        rpt_addr   <= addr;
        rpt_bits   <= err_bits;
        rpt_test   <= test;
        rpt_repeat <= CNT_W'(1);
      end else if (decision == DEC_REPEAT) begin
        rpt_repeat <= rpt_repeat + 1'b1;
      end
    end
  end
endmodule

// File: rtl/memerr_test_counters.sv
module memerr_test_counters #(
  parameter int TEST_W = 4,
  parameter int CNT_W  = 16,
  localparam int NUM_TESTS = 1 << TEST_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       accept,
  input  logic [TEST_W-1:0]          test,
  output logic [NUM_TESTS*CNT_W-1:0] counts
);
  for (genvar g = 0; g < NUM_TESTS; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt;
    logic             hit;
    assign hit = accept && (test == TEST_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else if (hit)   cnt <= cnt + 1'b1;
    end
    assign counts[g*CNT_W +: CNT_W] = cnt;
  end
endmodule

// File: rtl/memerr_summary.sv
module memerr_summary
  import memerr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TEST_W = 4,
  parameter int CNT_W  = 16,
  localparam int BITS_W    = $clog2(DATA_W + 1),
  localparam int TOT_W     = CNT_W + BITS_W,
  localparam int NUM_TESTS = 1 << TEST_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       evt_valid,
  input  logic [ADDR_W-1:0]          evt_addr,
  input  logic [DATA_W-1:0]          evt_expect,
  input  logic [DATA_W-1:0]          evt_read,
  input  logic [TEST_W-1:0]          evt_test,
  output logic [ADDR_W-1:0]          lo_addr,
  output logic [ADDR_W-1:0]          hi_addr,
  output logic [DATA_W-1:0]          bit_mask,
  output logic [TOT_W-1:0]           total_bits,
  output logic [CNT_W-1:0]           event_count,
  output logic [BITS_W-1:0]          min_bits,
  output logic [BITS_W-1:0]          max_bits,
  output logic [CNT_W-1:0]           max_run,
  output logic [NUM_TESTS*CNT_W-1:0] test_err_cnt,
  output logic                       rpt_valid,
  output logic [ADDR_W-1:0]          rpt_addr,
  output logic [DATA_W-1:0]          rpt_bits,
  output logic [TEST_W-1:0]          rpt_test,
  output logic [CNT_W-1:0]           rpt_repeat
);
  // Named internal events, visible to the bound checker.
  logic [DATA_W-1:0] err_bits;
  logic              accept;
  logic              first;
  logic [BITS_W-1:0] err_pop;
  logic [CNT_W-1:0]  cur_run;
  dedup_e            decision;

  assign err_bits = evt_expect ^ evt_read;
  assign accept   = evt_valid && !clear && (err_bits != '0);
  assign first    = (event_count == '0);

  memerr_bitstats #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_bits (
    .clk, .rst_n, .clear, .accept, .err_bits,
    .err_pop, .total_bits, .event_count, .min_bits, .max_bits
  );

  memerr_extent #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ext (
    .clk, .rst_n, .clear, .accept, .first,
    .addr(evt_addr), .prev_addr(rpt_addr), .err_bits,
    .lo_addr, .hi_addr, .bit_mask, .cur_run, .max_run
  );

  memerr_dedup #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TEST_W(TEST_W), .CNT_W(CNT_W)) u_dedup (
    .clk, .rst_n, .clear, .accept, .first,
    .addr(evt_addr), .err_bits, .test(evt_test),
    .decision, .rpt_valid, .rpt_addr, .rpt_bits, .rpt_test, .rpt_repeat
  );

  memerr_test_counters #(.TEST_W(TEST_W), .CNT_W(CNT_W)) u_tcnt (
    .clk, .rst_n, .clear, .accept, .test(evt_test), .counts(test_err_cnt)
  );
endmodule

// File: rtl/memerr_summary_chk.sv
module memerr_summary_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int BITS_W = 6,
  parameter int TOT_W  = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear,
  input logic              accept,
  input logic [ADDR_W-1:0] lo_addr,
  input logic [ADDR_W-1:0] hi_addr,
  input logic [DATA_W-1:0] bit_mask,
  input logic [CNT_W-1:0]  event_count,
  input logic [BITS_W-1:0] min_bits,
  input logic [BITS_W-1:0] max_bits,
  input logic [TOT_W-1:0]  total_bits,
  input logic [CNT_W-1:0]  cur_run,
  input logic [CNT_W-1:0]  max_run,
  input logic              rpt_valid,
  input logic [CNT_W-1:0]  rpt_repeat
);
  AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !clear) |=> $stable(event_count)); // R1
  AST_LO_LE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (event_count != '0) |-> (lo_addr <= hi_addr)); // R2
  AST_MASK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((bit_mask & $past(bit_mask)) == $past(bit_mask))); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (event_count == $past(event_count) + 1'b1)); // R4
  AST_MIN_LE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (event_count != '0) |-> (min_bits <= max_bits)); // R4
  AST_TOTAL_COVERS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    total_bits >= TOT_W'(max_bits)); // R4
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    max_run >= cur_run); // R5
  AST_REPORT_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> (rpt_repeat == CNT_W'(1))); // R6
  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (lo_addr == '1 && event_count == '0 && !rpt_valid && max_run == '0)); // R9
endmodule

bind memerr_summary memerr_summary_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .BITS_W(BITS_W), .TOT_W(TOT_W)
) u_chk (.*);

// File: tb/memerr_summary_tb.sv
`timescale 1ns/1ps
module memerr_summary_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int TEST_W = 4;
  localparam int CNT_W  = 16;
  localparam int BITS_W = 6;
  localparam int TOT_W  = 22;
  localparam int NT     = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic clear = 0;
  logic evt_valid = 0;
  logic [ADDR_W-1:0] evt_addr = '0;
  logic [DATA_W-1:0] evt_expect = '0, evt_read = '0;
  logic [TEST_W-1:0] evt_test = '0;
  logic [ADDR_W-1:0] lo_addr, hi_addr, rpt_addr;
  logic [DATA_W-1:0] bit_mask, rpt_bits;
  logic [TOT_W-1:0]  total_bits;
  logic [CNT_W-1:0]  event_count, max_run, rpt_repeat;
  logic [BITS_W-1:0] min_bits, max_bits;
  logic [NT*CNT_W-1:0] test_err_cnt;
  logic rpt_valid;
  logic [TEST_W-1:0] rpt_test;

  always #4 clk = ~clk;

  memerr_summary u_dut (.*);

  int checks = 0, fails = 0;

  // Bench model
  longint m_lo, m_hi, m_mask, m_total, m_count, m_min, m_max, m_run, m_maxrun;
  longint m_paddr, m_pbits, m_rep;
  longint m_tests [NT];

  typedef struct { longint addr; longint bits; longint test; } rpt_t;
  rpt_t exp_q[$];

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_lo = 64'hFFFF; m_hi = 0; m_mask = 0; m_total = 0; m_count = 0;
    m_min = 0; m_max = 0; m_run = 0; m_maxrun = 0; m_paddr = 0; m_pbits = 0; m_rep = 0;
    foreach (m_tests[i]) m_tests[i] = 0;
  endtask

  task automatic model_event(longint a, longint e, longint r, longint t);
    longint b, p;
    bit fresh;
    b = (e ^ r) & 64'hFFFF_FFFF;
    if (b == 0) return;
    p = 0;
    for (int i = 0; i < 32; i++) if (b[i]) p++;
    fresh = (m_count == 0) || (a != m_paddr) || (b != m_pbits);
    if (m_count != 0 && a == ((m_paddr + 1) & 64'hFFFF)) m_run++; else m_run = 1;
    if (m_run > m_maxrun) m_maxrun = m_run;
    if (a < m_lo) m_lo = a;
    if (a > m_hi) m_hi = a;
    m_mask |= b;
    m_total += p;
    if (m_count == 0 || p < m_min) m_min = p;
    if (p > m_max) m_max = p;
    m_count++;
    m_tests[t]++;
    if (fresh) begin
      rpt_t it;
      it.addr = a; it.bits = b; it.test = t;
      exp_q.push_back(it);
      m_rep = 1; m_paddr = a; m_pbits = b;
    end else m_rep++;
  endtask

  // Driver: one event, returns at the negedge after the sampling edge.
  task automatic ev(longint a, longint e, longint r, longint t, bit with_clear = 0);
    @(negedge clk);
    evt_valid = 1; evt_addr = a[ADDR_W-1:0]; evt_expect = e[DATA_W-1:0];
    evt_read = r[DATA_W-1:0]; evt_test = t[TEST_W-1:0]; clear = with_clear;
    if (with_clear) model_clear(); else model_event(a, e, r, t);
    @(negedge clk);
    evt_valid = 0; clear = 0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1; model_clear();
    @(negedge clk);
    clear = 0;
  endtask

  task automatic compare_all(string ctx);
    chk({ctx, " R2 lo_addr"}, lo_addr, m_lo);
    chk({ctx, " R2 hi_addr"}, hi_addr, m_hi);
    chk({ctx, " R3 bit_mask"}, bit_mask, m_mask);
    chk({ctx, " R4 total_bits"}, total_bits, m_total);
    chk({ctx, " R4 event_count"}, event_count, m_count);
    chk({ctx, " R4 min_bits"}, min_bits, m_min);
    chk({ctx, " R4 max_bits"}, max_bits, m_max);
    chk({ctx, " R5 max_run"}, max_run, m_maxrun);
    chk({ctx, " R7 rpt_repeat"}, rpt_repeat, m_rep);
    for (int t = 0; t < NT; t++)
      chk({ctx, $sformatf(" R8 test_err_cnt[%0d]", t)}, test_err_cnt[t*CNT_W +: CNT_W], m_tests[t]);
  endtask

  // Monitor: pops one expected report per observed pulse.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rpt_valid) begin
        if (exp_q.size() == 0) begin
          chk("R6 unexpected rpt_valid pulse", 1, 0);
        end else begin
          rpt_t it;
          it = exp_q.pop_front();
          chk("R6 rpt_addr", rpt_addr, it.addr);
          chk("R6 rpt_bits", rpt_bits, it.bits);
          chk("R6 rpt_test", rpt_test, it.test);
          chk("R6 rpt_repeat on new report", rpt_repeat, 1);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset lo_addr", lo_addr, 64'hFFFF);
    chk("R9 reset rpt_valid", rpt_valid, 0);
    compare_all("reset R9");

    // R6 first event, R10 visibility on the next cycle
    ev(16'h0010, 32'h0000_0000, 32'h0000_0001, 3);
    chk("R10 event_count one cycle after sampling edge", event_count, 1);
    compare_all("first");
    // R5 contiguous run 0x11, 0x12
    ev(16'h0011, 32'hFFFF_FFFF, 32'hFFFF_FFFC, 3);
    ev(16'h0012, 32'hFFFF_FFFF, 32'hFFFF_FFFC, 4);
    chk("R5 max_run after three consecutive", max_run, 3);
    compare_all("run");
    // R7 duplicate, then zero-xor event between duplicates (R1), then duplicate with other test
    ev(16'h0012, 32'h0, 32'h3, 4);
    chk("R7 rpt_repeat after duplicate", rpt_repeat, 2);
    ev(16'h0099, 32'h1234_5678, 32'h1234_5678, 7);
    chk("R1 zero-xor event leaves count", event_count, 4);
    chk("R1 zero-xor event leaves hi_addr", hi_addr, 16'h0012);
    ev(16'h0012, 32'h5, 32'h6, 9);
    chk("R7 rpt_repeat after duplicate from other test", rpt_repeat, 3);
    chk("R7 rpt_test unchanged", rpt_test, 4);
    chk("R5 run restarted by repeated address", max_run, 3);
    compare_all("dup");
    // R6 same address, different bits -> new report
    ev(16'h0012, 32'h0, 32'h8000_0000, 4);
    compare_all("newbits");
    // wide spread: low, high, full-width error
    ev(16'h0002, 32'hAAAA_AAAA, 32'h5555_5555, 15);
    ev(16'hFFF0, 32'h0F0F_0000, 32'h0000_0000, 0);
    chk("R4 max_bits full word", max_bits, 32);
    chk("R4 min_bits single bit", min_bits, 1);
    compare_all("spread");
    // R1 valid low carries no event
    @(negedge clk);
    evt_addr = 16'h0001; evt_expect = 32'h0; evt_read = 32'hFF;
    @(negedge clk);
    chk("R1 valid low ignored", event_count, m_count);
    // R9 clear together with an event: clear wins
    ev(16'h0100, 32'h0, 32'h1, 2, 1);
    chk("R9 clear beats event count", event_count, 0);
    chk("R9 clear lo_addr all ones", lo_addr, 64'hFFFF);
    compare_all("clear+ev");
    // R9 first event after clear is a new report even if it matches the old one
    ev(16'h0012, 32'h0, 32'h8000_0000, 4);
    chk("R9 new report after clear repeat", rpt_repeat, 1);
    ev(16'h0013, 32'h0, 32'h1, 1);
    compare_all("afterclear");
    do_clear();
    compare_all("clear R9");
    @(negedge clk);
    chk("R6 all expected reports seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule